// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C controller from the peripheral clock. While enabled it alternates a driven-low phase and a released-high phase, and it tells the byte sequencer when to change SDA (once in the middle of every low phase) and when to sample SDA (once per high phase). Before the first falling SCL edge of a transfer, it pulses the SDA change strobe and then waits a programmable number of peripheral clocks. This gives the start condition its setup time.

Two timing modes are selectable. In split mode the low and high phases come from separate 16-bit counts, a mask (sampling) delay and a rise/fall compensation count. Every count is in peripheral clocks and the prescaler is bypassed. In legacy mode a packed divider word holds a prescaler value and a coarse step value; the phases are counted in prescaled ticks. The high phase only starts counting once the synchronized SCL line reads high, so a target holding SCL low stretches the period.

Top module: `i2c_scl_timer`

## Requirements
- R1: During and directly after reset, `scl_drive_low`, `sample_stb` and `sda_stb` are all 0.
- R2: In split mode (`split_mode`=1), with SCL not held externally, the time between successive rising edges of `scl_drive_low` is 8 + 2×m + `low_cnt` + `high_cnt` + `comp_cnt` clocks. Here m is the effective mask delay (R6).
- R3: In split mode each driven-low phase (`scl_drive_low`=1) lasts `low_cnt` + m + 4 + `comp_cnt` clocks.
- R4: When enabling from idle, `sda_stb` pulses first and `scl_drive_low` rises exactly `setup_cnt` clocks later (a value of 0 acts as 1).
- R5: With `mask_en`=1 in split mode, `sample_stb` is a one-clock pulse m + SYNC_STAGES + 2 clocks after SCL is released, while SCL is released.
- R6: The effective mask delay m is `mask_dly` when `mask_dly` < `high_cnt`, and otherwise `high_cnt` − 1.
- R7: With `mask_en`=0 in split mode, `sample_stb` falls SYNC_STAGES + 2 + ⌊h/2⌋ clocks after release, where h = `high_cnt` + m + 3 − SYNC_STAGES.
- R8: `sda_stb` pulses once per low phase, u×(⌊n/2⌋+1) clocks after `scl_drive_low` rises, where n is the low length in units and u the unit length in clocks (1 in split mode).
- R9: In legacy mode (`split_mode`=0), `div_word` bits [CDF_W-1:0] are the prescaler value p, and the next STEP_W bits are the step s. One unit is p+1 clocks. The low phase lasts (10+4s+`comp_cnt`) units, and the period is (20+8s+`comp_cnt`)×(p+1) + SYNC_STAGES + 1 clocks.
- R10: While SCL is held low externally after release, the period grows by exactly the number of extra clocks SCL stays low.
- R11: Deasserting `run_en` during a running clock finishes the current period. SCL then stays released with no further low phase.
- R12: Deasserting `run_en` during the setup wait returns to idle without ever driving SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run the SCL generator |
| split_mode | input | 1 | 1: separate low/high counts, 0: legacy divider |
| mask_en | input | 1 | 1: sample at mask delay, 0: sample mid-high |
| low_cnt | input | CNT_W | Low-phase count (split mode) |
| high_cnt | input | CNT_W | High-phase count (split mode) |
| mask_dly | input | MASK_W | Sampling delay into the high phase |
| comp_cnt | input | COMP_W | Rise/fall compensation, added to the low phase |
| setup_cnt | input | SETUP_W | First-bit SDA-to-SCL setup in clocks |
| div_word | input | CDF_W+STEP_W | Legacy word: step above prescaler value |
| scl_in | input | 1 | SCL level seen on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sample_stb | output | 1 | One-clock SDA sample strobe |
| sda_stb | output | 1 | One-clock SDA change strobe |

## Verification
The corner cases are these:
- Clamping a mask delay that exceeds the high count. Without the clamp, the sample point and the period shift by the excess.
- Stretching by a held-low target. A counter that started on release instead of on the observed high level would keep the nominal period.
- Legacy field packing. Swapped prescaler and step fields would give a wrong period.
- Dropping the enable during the setup wait or mid-period. A wrong handling would either glitch SCL low or cut the period short.

A behavioural reference model predicts all three outputs on every clock.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_LOW   = 3'd2,
      PH_WAIT  = 3'd3,
      PH_HIGH  = 3'd4
   } scl_phase_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_scl_prescale.sv
module i2c_scl_prescale #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bypass,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] pcnt_q;
   logic             wrap;

   assign wrap = (pcnt_q == div);
   assign tick = bypass | wrap;

   always_ff @(posedge clk) begin
      if (!rst_n)                       pcnt_q <= '0;
      else if (restart || bypass || wrap) pcnt_q <= '0;
      else                              pcnt_q <= pcnt_q + 1'b1;
   end
endmodule

// File: rtl/i2c_scl_len_calc.sv
module i2c_scl_len_calc #(
   parameter int CNT_W    = 16,
   parameter int MASK_W   = 8,
   parameter int COMP_W   = 8,
   parameter int CDF_W    = 3,
   parameter int STEP_W   = 6,
   parameter int LEN_W    = 18,
   parameter int WAIT_LAT = 3
) (
   input  logic                    split_mode,
   input  logic                    mask_en,
   input  logic [CNT_W-1:0]        low_cnt,
   input  logic [CNT_W-1:0]        high_cnt,
   input  logic [MASK_W-1:0]       mask_dly,
   input  logic [COMP_W-1:0]       comp_cnt,
   input  logic [CDF_W+STEP_W-1:0] div_word,
   output logic [LEN_W-1:0]        low_len,
   output logic [LEN_W-1:0]        high_len,
   output logic [LEN_W-1:0]        smp_pt,
   output logic [LEN_W-1:0]        sda_pt,
   output logic [CDF_W-1:0]        pre_div
);
   localparam logic [LEN_W-1:0] FIXED_HALF = LEN_W'(4);
   localparam logic [LEN_W-1:0] LAT        = LEN_W'(WAIT_LAT);
   localparam logic [LEN_W-1:0] LEG_BASE   = LEN_W'(10);

   logic [CNT_W-1:0]  eff_mask;
   logic [LEN_W-1:0]  split_lo, split_hi_raw, split_hi;
   logic [LEN_W-1:0]  leg_base, leg_lo;
   logic [STEP_W-1:0] step;

   always_comb begin
      if (high_cnt == '0)                    eff_mask = '0;
      else if (CNT_W'(mask_dly) >= high_cnt) eff_mask = high_cnt - 1'b1;
      else                                   eff_mask = CNT_W'(mask_dly);
   end

   assign split_lo     = LEN_W'(low_cnt) + LEN_W'(eff_mask) + FIXED_HALF + LEN_W'(comp_cnt);
   assign split_hi_raw = LEN_W'(high_cnt) + LEN_W'(eff_mask) + FIXED_HALF - LAT;
   assign split_hi     = (split_hi_raw == '0) ? LEN_W'(1) : split_hi_raw;

   assign step     = div_word[CDF_W +: STEP_W];
   assign pre_div  = div_word[CDF_W-1:0];
   assign leg_base = LEG_BASE + (LEN_W'(step) << 2);
   assign leg_lo   = leg_base + LEN_W'(comp_cnt);

   always_comb begin
      if (split_mode) begin
         low_len  = split_lo;
         high_len = split_hi;
         smp_pt   = mask_en ? LEN_W'(eff_mask) : (split_hi >> 1);
      end else begin
         low_len  = leg_lo;
         high_len = leg_base;
         smp_pt   = leg_base >> 1;
      end
      sda_pt = low_len >> 1;
   end
endmodule

// File: rtl/i2c_scl_phase_fsm.sv
module i2c_scl_phase_fsm
   import i2c_scl_pkg::*;
#(
   parameter int LEN_W   = 18,
   parameter int SETUP_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic               tick,
   input  logic               scl_hi,
   input  logic [SETUP_W-1:0] setup_cnt,
   input  logic [LEN_W-1:0]   low_len,
   input  logic [LEN_W-1:0]   high_len,
   input  logic [LEN_W-1:0]   smp_pt,
   input  logic [LEN_W-1:0]   sda_pt,
   output logic               restart,
   output logic               drive_low,
   output logic               sample_stb,
   output logic               sda_stb
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   scl_phase_e       state_q, state_d;
   logic [LEN_W-1:0] cnt_q, cnt_d;
   logic             drv_q, drv_d, smp_d, sda_d, smp_q, sda_q;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      drv_d   = drv_q;
      smp_d   = 1'b0;
      sda_d   = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            drv_d = 1'b0;
            if (run_en) begin
               state_d = PH_SETUP;
               cnt_d   = '0;
               sda_d   = 1'b1;
            end
         end
         PH_SETUP: begin
            if (!run_en) begin
               state_d = PH_IDLE;
            end else if ((cnt_q + ONE) >= LEN_W'(setup_cnt)) begin
               state_d = PH_LOW;
               cnt_d   = '0;
               drv_d   = 1'b1;
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end
         PH_LOW: begin
            if (tick) begin
               if (cnt_q == sda_pt) sda_d = 1'b1;
               if (cnt_q == low_len - ONE) begin
                  state_d = PH_WAIT;
                  cnt_d   = '0;
                  drv_d   = 1'b0;
               end else begin
                  cnt_d = cnt_q + ONE;
               end
            end
         end
         PH_WAIT: begin
            if (scl_hi) begin
               state_d = PH_HIGH;
               cnt_d   = '0;
            end
         end
         PH_HIGH: begin
            if (tick) begin
               if (cnt_q == smp_pt) smp_d = 1'b1;
               if (cnt_q == high_len - ONE) begin
                  cnt_d = '0;
                  if (run_en) begin
                     state_d = PH_LOW;
                     drv_d   = 1'b1;
                  end else begin
                     state_d = PH_IDLE;
                  end
               end else begin
                  cnt_d = cnt_q + ONE;
               end
            end
         end
         default: begin
            state_d = PH_IDLE;
            drv_d   = 1'b0;
         end
      endcase
   end

   assign restart = (state_d != state_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         cnt_q   <= '0;
         drv_q   <= 1'b0;
         smp_q   <= 1'b0;
         sda_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         drv_q   <= drv_d;
         smp_q   <= smp_d;
         sda_q   <= sda_d;
      end
   end

   assign drive_low  = drv_q;
   assign sample_stb = smp_q;
   assign sda_stb    = sda_q;
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
   import i2c_scl_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int MASK_W      = 8,
   parameter int COMP_W      = 8,
   parameter int SETUP_W     = 8,
   parameter int CDF_W       = 3,
   parameter int STEP_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run_en,
   input  logic                    split_mode,
   input  logic                    mask_en,
   input  logic [CNT_W-1:0]        low_cnt,
   input  logic [CNT_W-1:0]        high_cnt,
   input  logic [MASK_W-1:0]       mask_dly,
   input  logic [COMP_W-1:0]       comp_cnt,
   input  logic [SETUP_W-1:0]      setup_cnt,
   input  logic [CDF_W+STEP_W-1:0] div_word,
   input  logic                    scl_in,
   output logic                    scl_drive_low,
   output logic                    sample_stb,
   output logic                    sda_stb
);
   localparam int WAIT_LAT = SYNC_STAGES + 1;
   localparam int BASE_W   = max_int(max_int(CNT_W, COMP_W), max_int(STEP_W + 2, SETUP_W));
   localparam int LEN_W    = BASE_W + 2;

   if (CDF_W < 2 || CDF_W > 3) begin : g_bad_cdf
      $error("CDF_W must be 2 or 3");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must be 1 to 3");
   end
   if (MASK_W > CNT_W) begin : g_bad_mask
      $error("MASK_W must not exceed CNT_W");
   end

   logic             scl_hi, tick, restart;
   logic [LEN_W-1:0] low_len, high_len, smp_pt, sda_pt;
   logic [CDF_W-1:0] pre_div;

   i2c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (scl_hi)
   );

   i2c_scl_len_calc #(
      .CNT_W    (CNT_W),
      .MASK_W   (MASK_W),
      .COMP_W   (COMP_W),
      .CDF_W    (CDF_W),
      .STEP_W   (STEP_W),
      .LEN_W    (LEN_W),
      .WAIT_LAT (WAIT_LAT)
   ) u_calc (
      .split_mode (split_mode),
      .mask_en    (mask_en),
      .low_cnt    (low_cnt),
      .high_cnt   (high_cnt),
      .mask_dly   (mask_dly),
      .comp_cnt   (comp_cnt),
      .div_word   (div_word),
      .low_len    (low_len),
      .high_len   (high_len),
      .smp_pt     (smp_pt),
      .sda_pt     (sda_pt),
      .pre_div    (pre_div)
   );

   i2c_scl_prescale #(.DIV_W(CDF_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .bypass  (split_mode),
      .restart (restart),
      .div     (pre_div),
      .tick    (tick)
   );

   i2c_scl_phase_fsm #(.LEN_W(LEN_W), .SETUP_W(SETUP_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .tick       (tick),
      .scl_hi     (scl_hi),
      .setup_cnt  (setup_cnt),
      .low_len    (low_len),
      .high_len   (high_len),
      .smp_pt     (smp_pt),
      .sda_pt     (sda_pt),
      .restart    (restart),
      .drive_low  (scl_drive_low),
      .sample_stb (sample_stb),
      .sda_stb    (sda_stb)
   );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic scl_drive_low,
   input logic sample_stb,
   input logic sda_stb
);
   AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !$past(scl_drive_low)); // R5

   AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb); // R5

   AST_SDA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sda_stb |=> !sda_stb); // R8

   AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |=> scl_drive_low); // R3

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !scl_drive_low) |=> !scl_drive_low); // R11
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .run_en        (run_en),
   .scl_drive_low (scl_drive_low),
   .sample_stb    (sample_stb),
   .sda_stb       (sda_stb)
);

// File: tb/i2c_scl_timer_test.sv
`timescale 1ns/1ps
module i2c_scl_timer_test;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        split_mode = 1'b1;
   logic        mask_en = 1'b1;
   logic [15:0] low_cnt = 16'd6;
   logic [15:0] high_cnt = 16'd5;
   logic [7:0]  mask_dly = 8'd3;
   logic [7:0]  comp_cnt = 8'd2;
   logic [7:0]  setup_cnt = 8'd17;
   logic [8:0]  div_word = 9'd0;
   logic        hold = 1'b0;
   logic        scl_drive_low, sample_stb, sda_stb;
   wire         bus_scl = !(scl_drive_low | hold);

   always #4 clk = ~clk;

   i2c_scl_timer uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .split_mode(split_mode),
      .mask_en(mask_en), .low_cnt(low_cnt), .high_cnt(high_cnt),
      .mask_dly(mask_dly), .comp_cnt(comp_cnt), .setup_cnt(setup_cnt),
      .div_word(div_word), .scl_in(bus_scl), .scl_drive_low(scl_drive_low),
      .sample_stb(sample_stb), .sda_stb(sda_stb)
   );

   int checks = 0, fails = 0, cyc = 0;
   int nrise = 0, rise_last = 0, rise_prev = 0, fall_last = 0, sda_last = 0, smp_last = 0;
   bit prev_drv = 0, done = 0;

   // reference model state
   int ph = 0, e = 0;
   bit exp_drv = 0, exp_smp = 0, exp_sda = 0;
   bit hist [0:3] = '{1'b1, 1'b1, 1'b1, 1'b1};
   int m_lo, m_hi, m_smp, m_sda, m_u;

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic model_lengths();
      int effm, step;
      if (split_mode) begin
         effm = (high_cnt == 0) ? 0 : ((mask_dly >= high_cnt) ? high_cnt - 1 : mask_dly);
         m_lo = low_cnt + effm + 4 + comp_cnt;
         m_hi = high_cnt + effm + 4 - (SYNC + 1);
         if (m_hi < 1) m_hi = 1;
         m_smp = mask_en ? effm : m_hi / 2;
         m_u = 1;
      end else begin
         step = div_word >> 3;
         m_lo = 10 + 4 * step + comp_cnt;
         m_hi = 10 + 4 * step;
         m_smp = m_hi / 2;
         m_u = (div_word & 9'd7) + 1;
      end
      m_sda = m_lo / 2;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         ph = 0; e = 0; exp_drv = 0; exp_smp = 0; exp_sda = 0;
         for (int i = 0; i < 4; i++) hist[i] = 1'b1;
      end else begin
         check_eq("R2 cycle model drive", scl_drive_low, exp_drv);
         check_eq("R5 cycle model sample", sample_stb, exp_smp);
         check_eq("R8 cycle model sda", sda_stb, exp_sda);
         if (scl_drive_low && !prev_drv) begin rise_prev = rise_last; rise_last = cyc; nrise++; end
         if (!scl_drive_low && prev_drv) fall_last = cyc;
         if (sda_stb) sda_last = cyc;
         if (sample_stb) smp_last = cyc;
         prev_drv = scl_drive_low;
         model_lengths();
         exp_smp = 0; exp_sda = 0;
         case (ph)
            0: if (run_en) begin ph = 1; e = 0; exp_sda = 1; end
            1: if (!run_en) ph = 0;
               else begin
                  e++;
                  if (e >= ((setup_cnt == 0) ? 1 : int'(setup_cnt))) begin ph = 2; e = 0; exp_drv = 1; end
               end
            2: begin
               e++;
               if (e == m_sda * m_u + m_u) exp_sda = 1;
               if (e == m_lo * m_u) begin ph = 3; e = 0; exp_drv = 0; end
            end
            3: if (hist[SYNC-1]) begin ph = 4; e = 0; end
            default: begin
               e++;
               if (e == m_smp * m_u + m_u) exp_smp = 1;
               if (e == m_hi * m_u) begin
                  e = 0;
                  if (run_en) begin ph = 2; exp_drv = 1; end
                  else ph = 0;
               end
            end
         endcase
         for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = bus_scl;
      end
   end

   task automatic set_en(input bit v);
      @(posedge clk); #2 run_en = v;
   endtask

   task automatic wait_rises(input int k);
      int target = nrise + k;
      while (nrise < target) @(posedge clk);
   endtask

   task automatic idle_cycles(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=done", cyc);
      finish_run();
   end

   initial begin
      int saved;
      repeat (3) @(negedge clk);
      check_eq("R1 reset drive", scl_drive_low, 0);
      check_eq("R1 reset sample", sample_stb, 0);
      check_eq("R1 reset sda", sda_stb, 0);
      @(posedge clk); #2 rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 after reset drive", scl_drive_low, 0);

      // split mode: L=6 H=5 M=3 C=2, setup 17
      set_en(1);
      wait_rises(1);
      check_eq("R4 setup to first edge", rise_last - sda_last, 17);
      wait_rises(2);
      check_eq("R2 split period", rise_last - rise_prev, 27);
      check_eq("R3 split low length", fall_last - rise_prev, 15);
      check_eq("R5 mask sample offset", smp_last - fall_last, 7);
      check_eq("R8 sda mid low", sda_last - rise_prev, 8);

      // stretch by 10 clocks
      while (scl_drive_low) begin @(posedge clk); #2; end
      hold = 1'b1;
      repeat (10) @(posedge clk);
      #2 hold = 1'b0;
      wait_rises(1);
      check_eq("R10 stretched period", rise_last - rise_prev, 37);
      wait_rises(1);
      check_eq("R10 period after stretch", rise_last - rise_prev, 27);

      // stop mid-low
      set_en(0);
      saved = nrise;
      idle_cycles(60);
      check_eq("R11 no edge after stop", nrise, saved);
      check_eq("R11 released after stop", scl_drive_low, 0);
      check_eq("R11 period completed", (fall_last > rise_last) ? 1 : 0, 1);

      // clamp: M=9 >= H=4 -> 3
      high_cnt = 16'd4; mask_dly = 8'd9;
      set_en(1);
      wait_rises(3);
      check_eq("R6 clamped period", rise_last - rise_prev, 26);
      check_eq("R6 clamped sample offset", smp_last - fall_last, 7);
      set_en(0); idle_cycles(60);

      // mask disabled: sample mid-high
      high_cnt = 16'd5; mask_dly = 8'd3; mask_en = 1'b0;
      set_en(1);
      wait_rises(3);
      check_eq("R7 mid-high sample offset", smp_last - fall_last, 8);
      check_eq("R2 period with mask off", rise_last - rise_prev, 27);
      set_en(0); idle_cycles(60);

      // legacy: prescaler 2, step 1, comp 1
      mask_en = 1'b1; split_mode = 1'b0; comp_cnt = 8'd1; div_word = 9'd10;
      set_en(1);
      wait_rises(3);
      check_eq("R9 legacy period", rise_last - rise_prev, 90);
      check_eq("R9 legacy low length", fall_last - rise_prev, 45);
      check_eq("R8 legacy sda offset", sda_last - rise_prev, 24);
      check_eq("R9 legacy sample offset", smp_last - fall_last, 27);
      set_en(0); idle_cycles(150);

      // abort during setup wait
      split_mode = 1'b1; comp_cnt = 8'd2; div_word = 9'd0;
      saved = nrise;
      set_en(1);
      idle_cycles(5);
      set_en(0);
      idle_cycles(40);
      check_eq("R12 no edge after setup abort", nrise, saved);
      check_eq("R12 released after setup abort", scl_drive_low, 0);

      finish_run();
   end
endmodule